// File: doc/BRIEF.md
# LPC I/O Target

This block is the device-side endpoint of a Low Pin Count bus for single-byte I/O reads and writes. It watches the host's frame strobe and the 4-bit multiplexed address/data lines, and qualifies each cycle by its start code and its cycle-type nibble. It claims only addresses inside a fixed, aligned 16-bit window and turns each claimed cycle into a one-clock read or write strobe toward local register logic.

While the local side is busy, the target holds the host off with wait codes. It reports an error code if no answer comes within a parameterised number of clocks. It hands the bus back with the usual two-clock turnaround. Holding the frame strobe low for four clocks or more aborts whatever is in progress. The lines are modelled as separate in/out/enable signals. The surrounding logic supplies the weak pull-up.

Top module: `lpc_io_target`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `lad_oe`, `reg_rd` and `reg_wr` are low.
- R2: The start code is the nibble sampled on the last low clock of `lframe_n`. Only 4'h0 (standard) and 4'h5 (trusted-module) cycles are claimed. Any other start code leaves the target silent for the whole cycle.
- R3: The nibble on the first clock with `lframe_n` high holds the cycle type in bits [3:2], where 2'b00 means I/O, and the direction in bit 1, where 1 means write. Cycle types other than I/O are not claimed.
- R4: The 16-bit address follows in four nibbles, most significant first. A cycle is claimed only if address bits [15:WIN_BITS] equal those of BASE_ADDR. On a miss, `lad_oe` never rises and the host sees 4'hF.
- R5: For a write, two data nibbles follow the address, low nibble first. `reg_wr` pulses for exactly one clock, on the first turnaround clock, with `reg_idx` equal to the address low bits and `reg_wdata` equal to the byte.
- R6: For a read, `reg_rd` pulses for exactly one clock, on the first turnaround clock. The byte on `reg_rdata` is captured when `rd_valid` is sampled high. After the ready code it is sent in two nibbles, low nibble first.
- R7: The target first drives on the third clock after the address (read) or the write data (write). It sends 4'h5 (wait) until an acknowledge sampled at a clock edge is seen, then sends 4'h0 (ready) on the following clock. An acknowledge given in the strobe clock or the next one produces no wait code.
- R8: After WAIT_LIMIT wait codes with no acknowledge, the target sends 4'hA (error), sends no read data, and goes straight to the final turnaround.
- R9: The final turnaround drives 4'hF for one clock and then releases `lad_oe`. The target drives only during the sync, read-data and first final-turnaround clocks.
- R10: `lad_oe` is low in any clock where `lframe_n` is low. After four or more low clocks, the cycle that follows is ignored whatever nibbles it carries, and the next normal cycle is served.
- R11: `reg_tpm` is high during a strobe exactly when the cycle's start code was 4'h5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lframe_n | input | 1 | Active-low frame/abort strobe from the host |
| lad_in | input | 4 | Sampled value of the shared address/data lines |
| lad_out | output | 4 | Value the target places on the lines |
| lad_oe | output | 1 | Output enable for `lad_out` |
| reg_idx | output | WIN_BITS | Register offset inside the window |
| reg_wdata | output | 8 | Write byte, valid with `reg_wr` |
| reg_wr | output | 1 | One-clock write strobe |
| reg_rd | output | 1 | One-clock read strobe |
| reg_tpm | output | 1 | Current cycle used the trusted-module start code |
| reg_rdata | input | 8 | Read byte from local logic |
| rd_valid | input | 1 | Read byte is valid on `reg_rdata` |
| wr_ack | input | 1 | Write has been accepted |

## Verification
The assertions assume a well-behaved host and local side. The host lowers `lframe_n` only to start or abort a cycle, and never drives the lines while the target holds them. The local side acknowledges only after a strobe, once per strobe. The stimulus drives host nibbles only in host-owned phases and floats them elsewhere, and raises `rd_valid` or `wr_ack` at a chosen delay counted from the strobe clock. A contention check flags any clock in which both sides drive.

// File: rtl/lpc_io_target.sv
module lpc_io_target #(
  parameter logic [15:0] BASE_ADDR  = 16'h0600,
  parameter int          WIN_BITS   = 3,
  parameter int          WAIT_LIMIT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lframe_n,
  input  logic [3:0]          lad_in,
  output logic [3:0]          lad_out,
  output logic                lad_oe,
  output logic [WIN_BITS-1:0] reg_idx,
  output logic [7:0]          reg_wdata,
  output logic                reg_wr,
  output logic                reg_rd,
  output logic                reg_tpm,
  input  logic [7:0]          reg_rdata,
  input  logic                rd_valid,
  input  logic                wr_ack
);

  localparam int          WCW      = $clog2(WAIT_LIMIT + 1);
  localparam logic [15:0] WIN_MASK = ~((16'd1 << WIN_BITS) - 16'd1);

  typedef enum logic [2:0] {IDLE, START, ADDR, WDATA, TAR1, SYNC, RDATA, TAR2} st_t;

  st_t            st;
  logic [1:0]     cnt;
  logic [2:0]     lowcnt;
  logic [3:0]     start_q;
  logic           is_wr, is_tpm, done;
  logic [15:0]    addr;
  logic [7:0]     data;
  logic [WCW-1:0] wcnt;

  wire [15:0] addr_nx  = {addr[11:0], lad_in};
  wire        start_ok = (start_q == 4'h0) || (start_q == 4'h5);
  wire        hit      = (addr_nx & WIN_MASK) == (BASE_ADDR & WIN_MASK);
  wire        ack      = is_wr ? wr_ack : rd_valid;
  wire        at_limit = (wcnt == WCW'(WAIT_LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; lowcnt <= '0; start_q <= '0;
      is_wr <= 1'b0; is_tpm <= 1'b0; done <= 1'b0;
      addr <= '0; data <= '0; wcnt <= '0;
    end else if (!lframe_n) begin
      st      <= START;
      start_q <= lad_in;
      lowcnt  <= (st != START) ? 3'd1 : (lowcnt[2] ? lowcnt : lowcnt + 3'd1);
      done    <= 1'b0;
    end else begin
      case (st)
        START: begin
          cnt <= '0;
          if (!lowcnt[2] && start_ok && lad_in[3:2] == 2'b00) begin
            st     <= ADDR;
            is_wr  <= lad_in[1];
            is_tpm <= (start_q == 4'h5);
          end else st <= IDLE;
        end
        ADDR: begin
          addr <= addr_nx;
          cnt  <= cnt + 2'd1;
          if (cnt == 2'd3) st <= !hit ? IDLE : (is_wr ? WDATA : TAR1);
        end
        WDATA: begin
          cnt <= cnt + 2'd1;
          if (cnt == 2'd0) data[3:0] <= lad_in;
          else begin
            data[7:4] <= lad_in;
            st  <= TAR1;
            cnt <= '0;
          end
        end
        TAR1: begin
          if (ack && !done) begin
            done <= 1'b1;
            if (!is_wr) data <= reg_rdata;
          end
          cnt <= cnt + 2'd1;
          if (cnt == 2'd1) begin
            st <= SYNC; cnt <= '0; wcnt <= '0;
          end
        end
        SYNC: begin
          if (done) st <= is_wr ? TAR2 : RDATA;
          else if (at_limit) st <= TAR2;
          else begin
            wcnt <= wcnt + WCW'(1);
            if (ack) begin
              done <= 1'b1;
              if (!is_wr) data <= reg_rdata;
            end
          end
        end
        RDATA: begin
          cnt <= cnt + 2'd1;
          if (cnt == 2'd1) begin st <= TAR2; cnt <= '0; end
        end
        TAR2: begin
          cnt <= cnt + 2'd1;
          if (cnt == 2'd1) st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      SYNC:    lad_out = done ? 4'h0 : (at_limit ? 4'hA : 4'h5);
      RDATA:   lad_out = cnt[0] ? data[7:4] : data[3:0];
      default: lad_out = 4'hF;
    endcase
  end

  assign lad_oe    = lframe_n & ((st == SYNC) | (st == RDATA) | (st == TAR2 && cnt == 2'd0));
  assign reg_rd    = (st == TAR1) && (cnt == 2'd0) && !is_wr;
  assign reg_wr    = (st == TAR1) && (cnt == 2'd0) && is_wr;
  assign reg_idx   = addr[WIN_BITS-1:0];
  assign reg_wdata = data;
  assign reg_tpm   = is_tpm;

  AST_RD_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n) reg_rd |=> !reg_rd); // R6
  AST_WR_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |=> !reg_wr); // R5
  AST_SYNC_EVEN_PARITY: assert property (@(posedge clk) disable iff (!rst_n) (st == SYNC && lframe_n) |-> (^lad_out) == 1'b0); // R7
  AST_TAR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (st == TAR2 && lad_oe) |=> !lad_oe); // R9
  AST_QUIET_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n) $rose(lframe_n) |-> !lad_oe); // R9
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (st == START && lframe_n && lowcnt[2]) |=> (!lad_oe && !reg_rd && !reg_wr)); // R10

endmodule

// File: tb/tb_lpc_io_target.sv
`timescale 1ns/1ps
module tb_lpc_io_target;
  localparam int LIMIT = 4;

  logic clk = 1'b0, rst_n = 1'b0, lframe_n = 1'b1;
  logic host_en = 1'b0; logic [3:0] host_val = 4'hF;
  logic [3:0] lad_bus, lad_out;
  logic lad_oe, reg_wr, reg_rd, reg_tpm, rd_valid = 1'b0, wr_ack = 1'b0;
  logic [2:0] reg_idx; logic [7:0] reg_wdata, reg_rdata = 8'h00;
  int checks = 0, failures = 0;
  logic cur_wr, cur_tpm; logic [7:0] cur_wd; logic [2:0] exp_idx;

  always #10 clk = ~clk;
  assign lad_bus = lad_oe ? lad_out : (host_en ? host_val : 4'hF);

  lpc_io_target #(.BASE_ADDR(16'h0600), .WIN_BITS(3), .WAIT_LIMIT(LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_in(lad_bus), .lad_out(lad_out),
    .lad_oe(lad_oe), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_tpm(reg_tpm), .reg_rdata(reg_rdata), .rd_valid(rd_valid), .wr_ack(wr_ack));

  task automatic step(input logic lf, input logic hen, input logic [3:0] hv, input logic ak,
                      input logic eoe, input logic [3:0] ev, input logic erd, input logic ewr,
                      input string tag);
    logic bad;
    lframe_n = lf; host_en = hen; host_val = hv;
    rd_valid = ak && !cur_wr; wr_ack = ak && cur_wr;
    #1;
    bad = (lad_oe !== eoe) || (eoe && lad_out !== ev) || (reg_rd !== erd) || (reg_wr !== ewr) || (hen && lad_oe);
    if ((erd || ewr) && (reg_idx !== exp_idx || reg_tpm !== cur_tpm || (ewr && reg_wdata !== cur_wd))) bad = 1'b1;
    checks++;
    if (bad) begin
      failures++;
      $display("FAIL %s t=%0t: oe=%b out=%h rd=%b wr=%b idx=%0d wd=%h tpm=%b expected oe=%b out=%h rd=%b wr=%b idx=%0d wd=%h tpm=%b",
               tag, $time, lad_oe, lad_out, reg_rd, reg_wr, reg_idx, reg_wdata, reg_tpm,
               eoe, ev, erd, ewr, exp_idx, cur_wd, cur_tpm);
    end
    @(negedge clk);
  endtask

  task automatic xact(input int lows, input logic [3:0] pre, input logic [3:0] st, input logic [3:0] ct,
                      input logic [15:0] a, input logic [7:0] wd, input int d, input logic [7:0] rv,
                      input int abort_k, input string tag);
    logic claim;
    claim = (lows < 4) && (st == 4'h0 || st == 4'h5) && (ct[3:2] == 2'b00) && (a[15:3] == 13'h00C0);
    cur_wr = ct[1]; cur_wd = wd; cur_tpm = (st == 4'h5); exp_idx = a[2:0]; reg_rdata = rv;
    for (int i = 0; i < lows; i++) step(1'b0, 1'b1, (i == lows - 1) ? st : pre, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, "R10");
    step(1'b1, 1'b1, ct, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, tag);
    for (int i = 3; i >= 0; i--) step(1'b1, 1'b1, a[i*4 +: 4], 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, "R4");
    if (cur_wr) begin
      step(1'b1, 1'b1, wd[3:0], 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, "R5");
      step(1'b1, 1'b1, wd[7:4], 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, "R5");
    end
    if (!claim) begin
      for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 4'hF, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, tag);
      return;
    end
    step(1'b1, 1'b1, 4'hF, d == 0, 1'b0, 4'h0, !cur_wr, cur_wr, cur_wr ? "R5 R11" : "R6 R11");
    step(1'b1, 1'b0, 4'hF, d == 1, 1'b0, 4'h0, 1'b0, 1'b0, "R7");
    for (int k = 0; ; k++) begin
      if (k == abort_k) begin
        for (int j = 0; j < 4; j++) step(1'b0, j == 3, 4'hF, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, "R10");
        step(1'b1, 1'b0, 4'hF, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, "R10");
        return;
      end
      if (k >= d - 1) begin
        step(1'b1, 1'b0, 4'hF, (2 + k) == d, 1'b1, 4'h0, 1'b0, 1'b0, "R7");
        if (!cur_wr) begin
          step(1'b1, 1'b0, 4'hF, 1'b0, 1'b1, rv[3:0], 1'b0, 1'b0, "R6");
          step(1'b1, 1'b0, 4'hF, 1'b0, 1'b1, rv[7:4], 1'b0, 1'b0, "R6");
        end
        break;
      end
      if (k == LIMIT) begin
        step(1'b1, 1'b0, 4'hF, 1'b0, 1'b1, 4'hA, 1'b0, 1'b0, "R8");
        break;
      end
      step(1'b1, 1'b0, 4'hF, (2 + k) == d, 1'b1, 4'h5, 1'b0, 1'b0, "R7");
    end
    step(1'b1, 1'b0, 4'hF, 1'b0, 1'b1, 4'hF, 1'b0, 1'b0, "R9");
    step(1'b1, 1'b0, 4'hF, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, "R9");
    step(1'b1, 1'b0, 4'hF, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, "R9");
  endtask

  initial begin
    cur_wr = 1'b0; cur_tpm = 1'b0; cur_wd = 8'h00; exp_idx = 3'd0;
    repeat (3) @(negedge clk);
    step(1'b1, 1'b0, 4'hF, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, "R1");
    rst_n = 1'b1;
    step(1'b1, 1'b0, 4'hF, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, "R1");
    xact(1, 4'h0, 4'h0, 4'h0, 16'h0603, 8'h00, 0, 8'hA5, -1, "R6");
    xact(1, 4'h0, 4'h0, 4'h2, 16'h0600, 8'h3C, 1, 8'h00, -1, "R5");
    xact(1, 4'h0, 4'h5, 4'h0, 16'h0607, 8'h00, 3, 8'h5E, -1, "R11");
    xact(1, 4'h0, 4'h5, 4'h2, 16'h0605, 8'hC3, 5, 8'h00, -1, "R7");
    xact(1, 4'h0, 4'h0, 4'h0, 16'h0601, 8'h00, 99, 8'h11, -1, "R8");
    xact(1, 4'h0, 4'h0, 4'h0, 16'h0610, 8'h00, 0, 8'h22, -1, "R4");
    xact(1, 4'h0, 4'h0, 4'h2, 16'h8606, 8'h77, 0, 8'h00, -1, "R4");
    xact(1, 4'h0, 4'h0, 4'h4, 16'h0602, 8'h00, 0, 8'h33, -1, "R3");
    xact(1, 4'h0, 4'h0, 4'h8, 16'h0602, 8'h00, 0, 8'h33, -1, "R3");
    xact(1, 4'h0, 4'h2, 4'h0, 16'h0602, 8'h00, 0, 8'h33, -1, "R2");
    xact(1, 4'h0, 4'hD, 4'h2, 16'h0602, 8'h44, 0, 8'h00, -1, "R2");
    xact(2, 4'h3, 4'h0, 4'h0, 16'h0604, 8'h00, 2, 8'h96, -1, "R2");
    xact(2, 4'h0, 4'h3, 4'h0, 16'h0604, 8'h00, 2, 8'h96, -1, "R2");
    xact(1, 4'h0, 4'h0, 4'h0, 16'h0602, 8'h00, 99, 8'h55, 2, "R10");
    xact(5, 4'h0, 4'h0, 4'h0, 16'h0602, 8'h00, 0, 8'h66, -1, "R10");
    xact(1, 4'h0, 4'h0, 4'h0, 16'h0606, 8'h00, 1, 8'hFF, -1, "R10 R6");
    xact(1, 4'h0, 4'h0, 4'h2, 16'h0603, 8'h0F, 99, 8'h00, -1, "R8");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule